// File: doc/BRIEF.md
# DDR3 Power-Up Initialization Sequencer

This block takes a DDR3 memory device from power-on to the point where it can accept normal traffic. After a local reset it holds the device reset pin low, then holds clock-enable low. After that it issues a fixed series of commands: three mode-register writes, a long ZQ calibration, a precharge of all banks and one refresh. Between steps it waits a programmable number of idle cycles.

One down-counter times every wait. A table indexed by the current step reloads the counter, and the step advances only when the counter reaches zero. Every idle cycle carries the NOP command with chip-select asserted, and bank and address at zero. When the last wait after the refresh ends, `init_done` rises and stays high. The surrounding controller then owns the command bus. From that point the sequencer drives only NOPs, so it can never issue a mode-register write or a ZQ calibration during normal operation.

All pin outputs are registered. Gap parameters give the number of idle cycles between two events, so consecutive events sit exactly gap+1 clock edges apart. Each gap therefore meets a "more than N clocks" rule when it is set to N.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, the outputs are `ddr_reset_n`=0, `ddr_cke`=0, `init_done`=0, command NOP, bank 0 and address 0. `ddr_reset_n` rises exactly T_RST_HOLD+1 clock edges after the first edge that samples `rst` low, and it never falls again without `rst`.
- R2: `ddr_cke` rises exactly T_CKE_HOLD+1 edges after `ddr_reset_n` rises. It stays high until `rst`, it is never high while `ddr_reset_n` is low, and no command other than NOP appears while it is low.
- R3: T_XPR+1 edges after `ddr_cke` rises, a mode-register write is issued ({cs_n,ras_n,cas_n,we_n}=0000) with bank 2 and address MR2_VAL (default 0x040).
- R4: T_MRD+1 edges after that, a mode-register write goes to bank 1 with address MR1_VAL. T_MRD+1 edges after that, another goes to bank 0 with address MR0_VAL (default 0x210).
- R5: T_MOD+1 edges after the bank-0 write, a ZQ calibration ({cs_n,ras_n,cas_n,we_n}=0110) is issued with address bit 10 set and every other address bit clear (long calibration), on bank 0.
- R6: T_ZQINIT+1 edges after the ZQ calibration, a precharge ({cs_n,ras_n,cas_n,we_n}=0010) is issued with address bit 10 set (all banks) on bank 0. T_RP+1 edges after that, a refresh (0001) is issued with bank 0 and address 0.
- R7: `init_done` rises exactly T_RFC+1 edges after the refresh and stays high until `rst`. Only NOPs appear from the refresh onward.
- R8: Every cycle that carries no command drives NOP (0111) with chip-select low, bank 0 and address 0. No mode-register write or ZQ calibration ever appears while `init_done` is high.
- R9: Each command occupies exactly one clock cycle.
- R10: Raising `rst` at any point returns all outputs to the R1 state at the next edge. After release, the whole sequence restarts from the device-reset hold with its full gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high local reset; restarts the sequence |
| ddr_reset_n | output | 1 | Device reset, active low |
| ddr_cke | output | 1 | Device clock enable |
| ddr_cs_n | output | 1 | Chip select, active low |
| ddr_ras_n | output | 1 | Row strobe, active low |
| ddr_cas_n | output | 1 | Column strobe, active low |
| ddr_we_n | output | 1 | Write enable, active low |
| ddr_ba | output | BA_W | Bank address |
| ddr_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | High once the device is ready; command bus handed over |

## Verification
If the step register holds the wrong value, the next event at the pins carries the wrong command, bank or address. If the counter is loaded from the wrong table entry, or is off by one, the spacing between two consecutive pin events is wrong. Either fault shows up at the very next event, at most one gap after the fault. A step machine that stalls produces no further events. One that skips a step delivers an event the expected order does not contain. A command that lingers for a second cycle shows up as an extra event on the following edge.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;

    // Sequencer steps, in the order they are performed
    typedef enum logic [3:0] {
        ST_RESET_HOLD,
        ST_CKE_HOLD,
        ST_MR2,
        ST_MR1,
        ST_MR0,
        ST_ZQCAL,
        ST_PREALL,
        ST_REFRESH,
        ST_SETTLE,
        ST_RUN
    } step_e;

    // Commands the sequencer can place on the bus
    typedef enum logic [2:0] {
        OP_NOP,
        OP_MRS,
        OP_REF,
        OP_PRE,
        OP_ZQL
    } op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    // Address bit that selects long calibration / all-bank precharge
    localparam int ALL_BIT = 10;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ddr_init_gap_cnt.sv
`timescale 1ns/1ps
module ddr_init_gap_cnt #(
    parameter int CNT_W   = 17,
    parameter int RST_VAL = 40000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_step_tbl.sv
`timescale 1ns/1ps
module ddr_init_step_tbl
    import ddr_init_pkg::*;
#(
    parameter int BA_W       = 3,
    parameter int ADDR_W     = 14,
    parameter int CNT_W      = 17,
    parameter int T_CKE_HOLD = 100000,
    parameter int T_XPR      = 147,
    parameter int T_MRD      = 3,
    parameter int T_MOD      = 11,
    parameter int T_ZQINIT   = 512,
    parameter int T_RP       = 3,
    parameter int T_RFC      = 140,
    parameter int MR2_VAL    = 'h040,
    parameter int MR1_VAL    = 'h044,
    parameter int MR0_VAL    = 'h210
) (
    input  step_e             step,
    output step_e             next_step,
    output op_e               op,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [CNT_W-1:0]  next_gap
);

    localparam logic [ADDR_W-1:0] ADDR_ALL = ADDR_W'(1 << ALL_BIT);

    // Per step: the action taken when its wait ends, and the wait of the successor
    always_comb begin
        next_step = step;
        op        = OP_NOP;
        ba        = '0;
        addr      = '0;
        next_gap  = '0;
        unique case (step)
            ST_RESET_HOLD: begin
                next_step = ST_CKE_HOLD;
                next_gap  = CNT_W'(T_CKE_HOLD);
            end
            ST_CKE_HOLD: begin
                next_step = ST_MR2;
                next_gap  = CNT_W'(T_XPR);
            end
            ST_MR2: begin
                next_step = ST_MR1;
                op        = OP_MRS;
                ba        = BA_W'(2);
                addr      = ADDR_W'(MR2_VAL);
                next_gap  = CNT_W'(T_MRD);
            end
            ST_MR1: begin
                next_step = ST_MR0;
                op        = OP_MRS;
                ba        = BA_W'(1);
                addr      = ADDR_W'(MR1_VAL);
                next_gap  = CNT_W'(T_MRD);
            end
            ST_MR0: begin
                next_step = ST_ZQCAL;
                op        = OP_MRS;
                ba        = BA_W'(0);
                addr      = ADDR_W'(MR0_VAL);
                next_gap  = CNT_W'(T_MOD);
            end
            ST_ZQCAL: begin
                next_step = ST_PREALL;
                op        = OP_ZQL;
                addr      = ADDR_ALL;
                next_gap  = CNT_W'(T_ZQINIT);
            end
            ST_PREALL: begin
                next_step = ST_REFRESH;
                op        = OP_PRE;
                addr      = ADDR_ALL;
                next_gap  = CNT_W'(T_RP);
            end
            ST_REFRESH: begin
                next_step = ST_SETTLE;
                op        = OP_REF;
                next_gap  = CNT_W'(T_RFC);
            end
            ST_SETTLE: begin
                next_step = ST_RUN;
            end
            default: begin
                next_step = ST_RUN;
            end
        endcase
    end

endmodule

// File: rtl/ddr_init_cmd_enc.sv
`timescale 1ns/1ps
module ddr_init_cmd_enc
    import ddr_init_pkg::*;
(
    input  op_e       op,
    output cmd_pins_t pins
);

    always_comb begin
        pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        unique case (op)
            OP_MRS:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};
            OP_REF:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
            OP_PRE:  pins = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
            OP_ZQL:  pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};
            default: pins = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
        endcase
    end

endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq
    import ddr_init_pkg::*;
#(
    parameter int BA_W        = 3,
    parameter int ADDR_W      = 14,
    parameter int T_RST_HOLD  = 40000,
    parameter int T_CKE_HOLD  = 100000,
    parameter int T_XPR       = 147,
    parameter int T_MRD       = 3,
    parameter int T_MOD       = 11,
    parameter int T_ZQINIT    = 512,
    parameter int T_RP        = 3,
    parameter int T_RFC       = 140,
    parameter int MR2_VAL     = 'h040,
    parameter int MR1_VAL     = 'h044,
    parameter int MR0_VAL     = 'h210
) (
    input  logic              clk,
    input  logic              rst,
    output logic              ddr_reset_n,
    output logic              ddr_cke,
    output logic              ddr_cs_n,
    output logic              ddr_ras_n,
    output logic              ddr_cas_n,
    output logic              ddr_we_n,
    output logic [BA_W-1:0]   ddr_ba,
    output logic [ADDR_W-1:0] ddr_addr,
    output logic              init_done
);

    localparam int MAX_GAP = max_of(max_of(max_of(T_RST_HOLD, T_CKE_HOLD),
                                           max_of(T_XPR, T_MRD)),
                                    max_of(max_of(T_MOD, T_ZQINIT),
                                           max_of(T_RP, T_RFC)));
    localparam int CNT_W = $clog2(MAX_GAP + 1);

    typedef struct packed {
        step_e             step;
        logic              reset_n;
        logic              cke;
        op_e               op;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        step: ST_RESET_HOLD, reset_n: 1'b0, cke: 1'b0, op: OP_NOP,
        ba: '0, addr: '0, done: 1'b0
    };

    seq_t seq_d, seq_q;

    logic              gap_zero;
    logic              advance;
    step_e             tbl_next;
    op_e               tbl_op;
    logic [BA_W-1:0]   tbl_ba;
    logic [ADDR_W-1:0] tbl_addr;
    logic [CNT_W-1:0]  tbl_gap;
    cmd_pins_t         pins;

    ddr_init_step_tbl #(
        .BA_W       (BA_W),
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .T_CKE_HOLD (T_CKE_HOLD),
        .T_XPR      (T_XPR),
        .T_MRD      (T_MRD),
        .T_MOD      (T_MOD),
        .T_ZQINIT   (T_ZQINIT),
        .T_RP       (T_RP),
        .T_RFC      (T_RFC),
        .MR2_VAL    (MR2_VAL),
        .MR1_VAL    (MR1_VAL),
        .MR0_VAL    (MR0_VAL)
    ) u_tbl (
        .step      (seq_q.step),
        .next_step (tbl_next),
        .op        (tbl_op),
        .ba        (tbl_ba),
        .addr      (tbl_addr),
        .next_gap  (tbl_gap)
    );

    ddr_init_gap_cnt #(
        .CNT_W   (CNT_W),
        .RST_VAL (T_RST_HOLD)
    ) u_gap (
        .clk      (clk),
        .rst      (rst),
        .load     (advance),
        .load_val (tbl_gap),
        .zero     (gap_zero)
    );

    assign advance = gap_zero && (seq_q.step != ST_RUN);

    always_comb begin
        seq_d      = seq_q;
        seq_d.op   = OP_NOP;
        seq_d.ba   = '0;
        seq_d.addr = '0;
        if (advance) begin
            seq_d.step = tbl_next;
            seq_d.op   = tbl_op;
            seq_d.ba   = tbl_ba;
            seq_d.addr = tbl_addr;
            unique case (seq_q.step)
                ST_RESET_HOLD: seq_d.reset_n = 1'b1;
                ST_CKE_HOLD:   seq_d.cke     = 1'b1;
                ST_SETTLE:     seq_d.done    = 1'b1;
                default:       ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    ddr_init_cmd_enc u_enc (
        .op   (seq_q.op),
        .pins (pins)
    );

    assign ddr_reset_n = seq_q.reset_n;
    assign ddr_cke     = seq_q.cke;
    assign ddr_cs_n    = pins.cs_n;
    assign ddr_ras_n   = pins.ras_n;
    assign ddr_cas_n   = pins.cas_n;
    assign ddr_we_n    = pins.we_n;
    assign ddr_ba      = seq_q.ba;
    assign ddr_addr    = seq_q.addr;
    assign init_done   = seq_q.done;

    // R1
    rstn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ddr_reset_n |=> ddr_reset_n)
        else $error("device reset fell without local reset");

    // R2
    cke_needs_rstn_chk: assert property (@(posedge clk) disable iff (rst)
        ddr_cke |-> ddr_reset_n)
        else $error("clock enable high while device in reset");

    // R2
    cke_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ddr_cke |=> ddr_cke)
        else $error("clock enable dropped");

    // R2
    no_cmd_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        !ddr_cke |-> {ddr_ras_n, ddr_cas_n, ddr_we_n} == 3'b111)
        else $error("command issued with clock enable low");

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done)
        else $error("done flag dropped");

    // R8
    run_nop_only_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |-> {ddr_ras_n, ddr_cas_n, ddr_we_n} == 3'b111)
        else $error("command issued after handover");

    // R9
    single_cycle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        ({ddr_ras_n, ddr_cas_n, ddr_we_n} != 3'b111)
        |=> ({ddr_ras_n, ddr_cas_n, ddr_we_n} == 3'b111))
        else $error("command held more than one cycle");

    // R10
    restart_chk: assert property (@(posedge clk)
        rst |=> (!ddr_reset_n && !ddr_cke && !init_done))
        else $error("outputs not returned to reset state");

endmodule

// File: tb/tb_ddr_init_seq.sv
`timescale 1ns/1ps
module tb_ddr_init_seq;

    localparam int BA_W       = 3;
    localparam int ADDR_W     = 14;
    localparam int T_RST_HOLD = 20;
    localparam int T_CKE_HOLD = 30;
    localparam int T_XPR      = 10;
    localparam int T_MRD      = 3;
    localparam int T_MOD      = 5;
    localparam int T_ZQINIT   = 12;
    localparam int T_RP       = 3;
    localparam int T_RFC      = 8;
    localparam int MR2_VAL    = 'h040;
    localparam int MR1_VAL    = 'h044;
    localparam int MR0_VAL    = 'h210;

    localparam int EV_RSTN = 0;
    localparam int EV_CKE  = 1;
    localparam int EV_CMD  = 2;
    localparam int EV_DONE = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              ddr_reset_n, ddr_cke, ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n;
    logic [BA_W-1:0]   ddr_ba;
    logic [ADDR_W-1:0] ddr_addr;
    logic              init_done;

    ddr_init_seq #(
        .BA_W(BA_W), .ADDR_W(ADDR_W),
        .T_RST_HOLD(T_RST_HOLD), .T_CKE_HOLD(T_CKE_HOLD), .T_XPR(T_XPR),
        .T_MRD(T_MRD), .T_MOD(T_MOD), .T_ZQINIT(T_ZQINIT), .T_RP(T_RP),
        .T_RFC(T_RFC), .MR2_VAL(MR2_VAL), .MR1_VAL(MR1_VAL), .MR0_VAL(MR0_VAL)
    ) dut (
        .clk(clk), .rst(rst),
        .ddr_reset_n(ddr_reset_n), .ddr_cke(ddr_cke), .ddr_cs_n(ddr_cs_n),
        .ddr_ras_n(ddr_ras_n), .ddr_cas_n(ddr_cas_n), .ddr_we_n(ddr_we_n),
        .ddr_ba(ddr_ba), .ddr_addr(ddr_addr), .init_done(init_done)
    );

    typedef struct {
        string    req;
        int       kind;
        int       gap;
        logic [2:0] rcw;
        int       ba;
        int       addr;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   fail  = 0;
    int   popped = 0;
    int   cnt = 0;
    logic prev_rstn = 1'b0, prev_cke = 1'b0, prev_done = 1'b0;
    logic [2:0] rcw_now;
    bit   finished = 0;

    task automatic chk(input string r, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fail++;
            $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
        end
    endtask

    task automatic push_ev(input string r, input int k, input int g,
                           input logic [2:0] rcw, input int ba, input int addr);
        exp_t e;
        e.req = r; e.kind = k; e.gap = g; e.rcw = rcw; e.ba = ba; e.addr = addr;
        exp_q.push_back(e);
    endtask

    // Driver side: the expected event stream, in order, with the idle gap before each
    task automatic push_seq();
        push_ev("R1", EV_RSTN, T_RST_HOLD, 3'b111, 0, 0);
        push_ev("R2", EV_CKE,  T_CKE_HOLD, 3'b111, 0, 0);
        push_ev("R3", EV_CMD,  T_XPR,      3'b000, 2, MR2_VAL);
        push_ev("R4", EV_CMD,  T_MRD,      3'b000, 1, MR1_VAL);
        push_ev("R4", EV_CMD,  T_MRD,      3'b000, 0, MR0_VAL);
        push_ev("R5", EV_CMD,  T_MOD,      3'b110, 0, 'h400);
        push_ev("R6", EV_CMD,  T_ZQINIT,   3'b010, 0, 'h400);
        push_ev("R6", EV_CMD,  T_RP,       3'b001, 0, 0);
        push_ev("R7", EV_DONE, T_RFC,      3'b111, 0, 0);
    endtask

    task automatic take_event(input int k);
        exp_t e;
        if (exp_q.size() == 0) begin
            // R9: a held or extra command appears as an event nobody expects
            chk("R9", "unexpected event kind", k, -1);
        end else begin
            e = exp_q.pop_front();
            popped++;
            chk(e.req, "event kind", k, e.kind);
            chk(e.req, "edges since previous event", cnt, e.gap + 1);
            if (e.kind == EV_CMD) begin
                chk(e.req, "command ras/cas/we", int'(rcw_now), int'(e.rcw));
                chk(e.req, "bank", int'(ddr_ba), e.ba);
                chk(e.req, "address", int'(ddr_addr), e.addr);
            end
        end
        cnt = 0;
    endtask

    task automatic rst_state_chk(input string r);
        chk(r, "reset_n in reset", int'(ddr_reset_n), 0);
        chk(r, "cke in reset", int'(ddr_cke), 0);
        chk(r, "done in reset", int'(init_done), 0);
        chk(r, "cmd pins in reset", int'({ddr_cs_n, ddr_ras_n, ddr_cas_n, ddr_we_n}), 'b0111);
        chk(r, "bank in reset", int'(ddr_ba), 0);
        chk(r, "address in reset", int'(ddr_addr), 0);
    endtask

    // Monitor: pops and compares events as the pins produce them
    always @(negedge clk) begin
        if (rst) begin
            cnt = 0;
            prev_rstn = 1'b0;
            prev_cke  = 1'b0;
            prev_done = 1'b0;
        end else if (!finished) begin
            rcw_now = {ddr_ras_n, ddr_cas_n, ddr_we_n};
            chk("R8", "chip select low", int'(ddr_cs_n), 0);
            if (rcw_now == 3'b111) begin
                chk("R8", "idle bank", int'(ddr_ba), 0);
                chk("R8", "idle address", int'(ddr_addr), 0);
            end
            if (ddr_reset_n && !prev_rstn) take_event(EV_RSTN);
            if (ddr_cke && !prev_cke)      take_event(EV_CKE);
            if (rcw_now != 3'b111)         take_event(EV_CMD);
            if (init_done && !prev_done)   take_event(EV_DONE);
            prev_rstn = ddr_reset_n;
            prev_cke  = ddr_cke;
            prev_done = init_done;
            cnt++;
        end
    end

    task automatic summary();
        finished = 1;
        $display("%0d/%0d checks passed", total - fail, total);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_state_chk("R1");
        push_seq();
        @(posedge clk); #1 rst = 1'b0;

        // R10: interrupt after the bank-1 mode write, then restart from scratch
        wait (popped == 4);
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_state_chk("R10");
        exp_q.delete();
        popped = 0;
        push_seq();
        @(posedge clk); #1 rst = 1'b0;

        wait (popped == 9);
        repeat (25) @(negedge clk);
        chk("R7", "done held", int'(init_done), 1);
        chk("R7", "expected events drained", exp_q.size(), 0);
        chk("R2", "cke held", int'(ddr_cke), 1);

        // R10: reset after handover drops everything again
        @(posedge clk); #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst_state_chk("R10");
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            fail++;
            $display("FAIL R7 watchdog: actual timeout expected sequence completion");
            summary();
        end
    end

endmodule